// File: doc/BRIEF.md
# Audio Port Frame Counter and Event Interrupt Register

This block holds the interrupt control word of an audio serial port together with a free-running frame counter and a frame-match comparator. Software reaches three 32-bit registers over a simple register bus. The bus has one write strobe and a combinational read port. Register words sit 16 bytes apart, so address bits above bit 3 select the word and bits 3:0 are ignored.

Eight interrupt sources each own an enable/pending bit pair in the upper half of the control word. A single-cycle strobe on a source input sets that source's pending flag. Software clears a pending flag by writing 1 to it. The frame counter advances on a frame strobe from the serializer. When the count changes to the value held in the match register, the frame-count source is raised. The level interrupt output stays high while any enabled source is pending.

Top module: `frame_irq_regs`

## Requirements
- R1: After reset the control word, the frame count and the match value all read 0, and `irq_o` is 0.
- R2: Source k (0 to 7) has its enable at control bit 17+2k and its pending flag at bit 16+2k. Source 7 is the frame-count source, with enable in bit 31 and pending in bit 30. Bits 15:0 of the control word read 0, whatever was written to them.
- R3: A 1 on `evt_in[k]` in one cycle sets pending flag k at the next clock edge, and the flag stays set until it is cleared.
- R4: A write to word 0x00 loads every enable bit from the write data. It clears each pending flag whose bit is written 1 and leaves each flag whose bit is written 0.
- R5: When a source strobe and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R6: `irq_o` is 1 exactly when at least one source has both its enable and its pending flag set. It follows register state with no added delay.
- R7: The frame count at word 0x40 rises by one on every cycle with `frame_tick` high, and wraps from 0xFFFFFFFF to 0.
- R8: A write to word 0x40 loads the frame count. If a frame tick falls in the same cycle, the written value wins.
- R9: Word 0x50 holds the match value. The frame-count pending flag (bit 30) is set at the edge where the count changes to a value equal to the match value, whether by tick or by load. It is not set again while the two stay equal. It is not set when the match register or the count is written with the value the count already holds.
- R10: Words other than 0x00, 0x40 and 0x50 read as 0, and writes to them change no register.
- R11: Address bits 3:0 are ignored, so offset 0x44 reads the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 8 | Single-cycle source strobes, bit k for source k |
| frame_tick | input | 1 | Frame strobe from the serializer |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that every input is synchronous to `clk` and is held steady across each rising edge. They also assume that a frame tick is one cycle long, so each tick advances the count by exactly one. The bench drives all inputs on the falling edge and holds each write, strobe and tick for one full cycle. Simultaneous stimulus is applied only on purpose: a strobe with a clear, and a tick with a count load. Reads are checked through the bus port half a cycle after the edge that updated the state.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_NUM_SRC = 8;
    localparam int unsigned DEF_ADDR_W  = 8;
    // registers are spaced 16 bytes apart
    localparam int unsigned WORD_SHIFT  = 4;
    localparam int unsigned IDX_CTRL    = 0;
    localparam int unsigned IDX_COUNT   = 4;
    localparam int unsigned IDX_MATCH   = 5;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_COUNT,
        SEL_MATCH
    } reg_sel_e;
endpackage

// File: rtl/frm_irq_decode.sv
module frm_irq_decode
    import frm_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned IDX_W = ADDR_W - WORD_SHIFT;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:WORD_SHIFT];

    always_comb begin
        sel = SEL_NONE;
        if (idx == IDX_W'(IDX_CTRL))       sel = SEL_CTRL;
        else if (idx == IDX_W'(IDX_COUNT)) sel = SEL_COUNT;
        else if (idx == IDX_W'(IDX_MATCH)) sel = SEL_MATCH;
    end
endmodule

// File: rtl/frm_irq_bank.sv
module frm_irq_bank #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [NUM_SRC-1:0] wr_en_bits,
    input  logic [NUM_SRC-1:0] wr_clr,
    input  logic [NUM_SRC-1:0] set,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] pend,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.en   = wr_en_bits;
            st_d.pend = st_q.pend & ~wr_clr;
        end
        // a strobe outranks a clear in the same cycle
        st_d.pend = st_d.pend | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = st_q.en;
    assign pend = st_q.pend;
    assign irq  = |(st_q.en & st_q.pend);
endmodule

// File: rtl/frm_counter.sv
module frm_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_cnt,
    input  logic              ld_match,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] match,
    output logic              hit
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] match;
    } fc_t;

    fc_t fc_d, fc_q;

    always_comb begin
        fc_d = fc_q;
        if (ld_cnt)    fc_d.cnt = wdata;
        else if (tick) fc_d.cnt = fc_q.cnt + DATA_W'(1);
        if (ld_match)  fc_d.match = wdata;
        // edge-type match: only when the count moves onto the match value
        hit = (fc_d.cnt != fc_q.cnt) && (fc_d.cnt == fc_q.match);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fc_q <= '0;
        else        fc_q <= fc_d;
    end

    assign cnt   = fc_q.cnt;
    assign match = fc_q.match;
endmodule

// File: rtl/frame_irq_regs.sv
module frame_irq_regs
    import frm_irq_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned ADDR_W  = DEF_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               frame_tick,
    output logic               irq_o
);
    localparam int unsigned PAIR_LSB  = DATA_W - 2 * NUM_SRC;
    localparam int unsigned FRAME_SRC = NUM_SRC - 1;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wen_bits, wclr_bits, set_vec, en_w, pend_w;
    logic [DATA_W-1:0]  ctrl_word, cnt_w, match_w;
    logic               hit;

    frm_irq_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_pair
        assign wen_bits[k]              = bus_wdata[PAIR_LSB + 2*k + 1];
        assign wclr_bits[k]             = bus_wdata[PAIR_LSB + 2*k];
        assign ctrl_word[PAIR_LSB+2*k+1] = en_w[k];
        assign ctrl_word[PAIR_LSB+2*k]   = pend_w[k];
    end
    if (PAIR_LSB > 0) begin : g_low
        assign ctrl_word[PAIR_LSB-1:0] = '0;
    end

    assign set_vec = evt_in | (NUM_SRC'(hit) << FRAME_SRC);

    frm_irq_bank #(.NUM_SRC(NUM_SRC)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr && sel == SEL_CTRL),
        .wr_en_bits (wen_bits),
        .wr_clr     (wclr_bits),
        .set        (set_vec),
        .en         (en_w),
        .pend       (pend_w),
        .irq        (irq_o)
    );

    frm_counter #(.DATA_W(DATA_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (frame_tick),
        .ld_cnt   (bus_wr && sel == SEL_COUNT),
        .ld_match (bus_wr && sel == SEL_MATCH),
        .wdata    (bus_wdata),
        .cnt      (cnt_w),
        .match    (match_w),
        .hit      (hit)
    );

    always_comb begin
        case (sel)
            SEL_CTRL:  bus_rdata = ctrl_word;
            SEL_COUNT: bus_rdata = cnt_w;
            SEL_MATCH: bus_rdata = match_w;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/frm_irq_chk.sv
module frm_irq_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] evt_in,
    input logic               frame_tick,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend,
    input logic [DATA_W-1:0]  cnt
);
    localparam int unsigned PAIR_LSB = DATA_W - 2 * NUM_SRC;
    localparam int unsigned IDX_W    = ADDR_W - 4;

    logic [NUM_SRC-1:0] clr_bits, rd_active;
    logic               at_ctrl, at_count;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bits
        assign clr_bits[k]  = bus_wdata[PAIR_LSB + 2*k];
        assign rd_active[k] = bus_rdata[PAIR_LSB+2*k+1] & bus_rdata[PAIR_LSB+2*k];
    end
    assign at_ctrl  = bus_addr[ADDR_W-1:4] == IDX_W'(0);
    assign at_count = bus_addr[ADDR_W-1:4] == IDX_W'(4);

    // R3
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((pend & $past(evt_in)) == $past(evt_in)));

    // R4
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_ctrl && clr_bits == '0) |=> ((pend & $past(pend)) == $past(pend)));

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_ctrl |-> (irq_o == (rd_active != '0)));

    // R2
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_ctrl |-> (bus_rdata[PAIR_LSB-1:0] == '0));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !(bus_wr && at_count)) |=> (cnt == $past(cnt) + DATA_W'(1)));

    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_count) |=> (cnt == $past(bus_wdata)));
endmodule

bind frame_irq_regs frm_irq_chk #(
    .DATA_W  (DATA_W),
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
) i_frm_irq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .evt_in     (evt_in),
    .frame_tick (frame_tick),
    .irq_o      (irq_o),
    .pend       (pend_w),
    .cnt        (cnt_w)
);

// File: tb/test_frame_irq_regs.sv
module test_frame_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_in = '0;
    logic        frame_tick = 1'b0;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    logic [32:0] exp_q[$];   // bit 32 set: compare irq_o, else bus_rdata
    string       tag_q[$];

    always #5 clk = ~clk;

    frame_irq_regs i_frame_irq_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_in     (evt_in),
        .frame_tick (frame_tick),
        .irq_o      (irq_o)
    );

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        exp_q.push_back({1'b0, e});
        tag_q.push_back(t);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        exp_q.push_back({1'b1, 31'd0, e});
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_in = ev;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; frame_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; frame_tick = 1'b0;
    endtask

    task automatic pulse_evt(input logic [7:0] ev);
        @(negedge clk);
        evt_in = ev;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_tick = 1'b1;
            @(negedge clk);
            frame_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: pops expected items and compares them against the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                logic [32:0] it;
                string       t;
                it = exp_q.pop_front();
                t  = tag_q.pop_front();
                total++;
                if (it[32]) begin
                    if (irq_o !== it[0]) begin
                        bad++;
                        $display("FAIL %s irq_o actual=%0b expected=%0b", t, irq_o, it[0]);
                    end
                end else if (bus_rdata !== it[31:0]) begin
                    bad++;
                    $display("FAIL %s addr=%02h actual=%08h expected=%08h",
                             t, bus_addr, bus_rdata, it[31:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd(8'h00, 32'h0, "R1 ctrl");
        chk_rd(8'h40, 32'h0, "R1 count");
        chk_rd(8'h50, 32'h0, "R1 match");
        chk_irq(1'b0, "R1 irq");

        // R10 match register read/write
        wr(8'h50, 32'h12);
        chk_rd(8'h50, 32'h12, "R10 match rw");

        // R2 / R4 enables are read/write, low half reads zero
        wr(8'h00, 32'hAAAA_FFFF);
        chk_rd(8'h00, 32'hAAAA_0000, "R2 low bits zero");
        chk_irq(1'b0, "R6 enabled none pending");
        wr(8'h00, 32'h0);
        chk_rd(8'h00, 32'h0, "R4 enables off");

        // R3 strobes set pending, R6 disabled sources stay quiet
        pulse_evt(8'h05);
        chk_rd(8'h00, 32'h0011_0000, "R3 pend src0 src2");
        chk_irq(1'b0, "R6 disabled");
        wr(8'h00, 32'h0020_0000);
        chk_rd(8'h00, 32'h0031_0000, "R4 write0 keeps pending");
        chk_irq(1'b1, "R6 enabled pending");
        wr(8'h00, 32'h0030_0000);
        chk_rd(8'h00, 32'h0021_0000, "R4 write1 clears");
        chk_irq(1'b0, "R6 after clear");

        // R5 set beats clear
        pulse_evt(8'h02);
        chk_rd(8'h00, 32'h0025_0000, "R3 pend src1");
        wr_evt(8'h00, 32'h0024_0000, 8'h02);
        chk_rd(8'h00, 32'h0025_0000, "R5 set wins");
        wr(8'h00, 32'h0025_0000);
        chk_rd(8'h00, 32'h0020_0000, "R4 clear two");

        // R7 counting and wrap
        tick(3);
        chk_rd(8'h40, 32'h3, "R7 three ticks");
        wr(8'h40, 32'hFFFF_FFFE);
        chk_rd(8'h40, 32'hFFFF_FFFE, "R8 load");
        tick(2);
        chk_rd(8'h40, 32'h0, "R7 wrap");
        wr_tick(8'h40, 32'h10);
        chk_rd(8'h40, 32'h10, "R8 load beats tick");

        // R9 match by tick
        wr(8'h00, 32'h8000_0000);
        tick(1);
        chk_rd(8'h00, 32'h8000_0000, "R9 not yet equal");
        chk_irq(1'b0, "R9 no irq before match");
        tick(1);
        chk_rd(8'h00, 32'hC000_0000, "R9 match by tick");
        chk_irq(1'b1, "R9 irq on match");
        wr(8'h00, 32'hC000_0000);
        chk_rd(8'h00, 32'h8000_0000, "R9 cleared");
        chk_rd(8'h00, 32'h8000_0000, "R9 no refire while equal");
        wr(8'h50, 32'h20);
        wr(8'h50, 32'h12);
        chk_rd(8'h00, 32'h8000_0000, "R9 match write equal count");
        wr(8'h40, 32'h12);
        chk_rd(8'h00, 32'h8000_0000, "R9 load same value");
        wr(8'h40, 32'h11);
        wr(8'h40, 32'h12);
        chk_rd(8'h00, 32'hC000_0000, "R9 match by load");
        wr(8'h00, 32'hC000_0000);
        chk_rd(8'h00, 32'h8000_0000, "R9 cleared again");

        // R10 unmapped, R11 low address bits
        wr(8'h30, 32'hFFFF_FFFF);
        chk_rd(8'h30, 32'h0, "R10 unmapped reads zero");
        chk_rd(8'h00, 32'h8000_0000, "R10 ctrl untouched");
        chk_rd(8'h40, 32'h12, "R10 count untouched");
        chk_rd(8'h50, 32'h12, "R10 match untouched");
        chk_rd(8'h44, 32'h12, "R11 offset 0x44");

        // R2 full layout with every source
        pulse_evt(8'hFF);
        chk_rd(8'h00, 32'hD555_0000, "R2 all pending");
        chk_irq(1'b1, "R6 src7");
        wr(8'h00, 32'h5555_0000);
        chk_rd(8'h00, 32'h0, "R4 clear all");
        chk_irq(1'b0, "R6 all clear");

        @(negedge clk);
        #3;
        finish_run();
    end
endmodule